// File: doc/BRIEF.md
# PCI Type 1 Configuration Router

This block sits on the upstream side of a PCI-to-PCI bridge and inspects the address phase of every configuration transaction. It keeps three programmable bus numbers (primary, secondary, subordinate). For each cycle it decides whether the bridge claims it and how the cycle continues downstream.

A type 1 cycle whose target bus is the bridge's secondary bus becomes a type 0 cycle. In that cycle, a single upper address line acts as the device select. A type 1 cycle aimed at a bus deeper in the hierarchy is passed on unchanged. Any other type 1 cycle is left unclaimed, so the initiator sees a master abort. A type 0 cycle whose device select input is high targets the bridge's own header. A write to the bus-number dword updates the registers, and a read of that dword returns their values.

The design has one state machine with two named states. ST_IDLE means no result is pending. ST_REPORT means a result is presented this cycle. There are four transitions:
- IDLE→REPORT when a strobe arrives.
- REPORT→REPORT when another strobe arrives in the reporting cycle.
- REPORT→IDLE when no strobe arrives.
- IDLE→IDLE when no strobe arrives.

Top module: `cfg_route_top`

## Requirements
- R1: After reset, all three bus numbers are 00h, `res_vld` is 0, and every result output is 0.
- R2: For each cycle with `ap_strobe` high, `res_vld` is high for exactly the following cycle, carrying that cycle's result. `res_vld` never rises without a strobe one cycle earlier.
- R3: A type 1 cycle (address bits 1:0 = 01) whose bus field (bits 23:16) equals the secondary bus number gives action code 2 (convert) and `res_claim` = 1.
- R4: The converted address is formed as follows. Bits 1:0 are 00. Bits 10:2 are copied from the input. Bits 15:11 are 0. Bits 31:16 are one-hot, with device field N (bits 15:11) setting bit 16+N for N in 0..15.
- R5: A converted cycle with device number 16..31 is still claimed with action 2, but bits 31:16 of the address are all zero.
- R6: A type 1 cycle whose bus field is greater than the secondary bus number and no greater than the subordinate bus number gives action code 3 (forward), `res_claim` = 1, and the address unchanged.
- R7: Any other type 1 cycle gives action code 0 (none), `res_claim` = 0, and address 0. This includes a bus field below or equal to the primary bus number, a bus field above the subordinate number, and every bus field when subordinate < secondary.
- R8: A type 0 cycle (bits 1:0 = 00) with `ap_idsel` high gives action code 1 (local) with `res_claim` = 1. The same cycle with `ap_idsel` low gives action 0.
- R9: An address with bits 1:0 equal to 10 or 11 gives action 0 whatever `ap_idsel` is.
- R10: A local write to register number 6 (offset 18h) updates the bus numbers at the edge that samples the strobe. Byte enable 0 writes data bits 7:0 to primary, enable 1 writes bits 15:8 to secondary, and enable 2 writes bits 23:16 to subordinate. Enable 3, other register numbers, reads and non-local cycles change nothing.
- R11: A local read of register number 6 returns {8'h00, subordinate, secondary, primary} on `res_rdata`. Every other result carries `res_rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ap_strobe | input | 1 | Address phase present this cycle |
| ap_addr | input | 32 | Address-phase word |
| ap_is_write | input | 1 | 1 for configuration write, 0 for read |
| ap_idsel | input | 1 | Device select of the bridge itself for type 0 cycles |
| ap_byte_en | input | 4 | Byte enables of the write data (active high) |
| ap_wdata | input | 32 | Write data for local writes |
| res_vld | output | 1 | One-cycle result pulse |
| res_act | output | 2 | 0 none, 1 local, 2 convert, 3 forward |
| res_claim | output | 1 | Bridge claims the cycle (device select response) |
| res_addr | output | 32 | Downstream address for convert or forward, else 0 |
| res_rdata | output | 32 | Read data for a local bus-number read, else 0 |

## Verification
The bench targets the edges of the range compare:
- A bus field equal to the secondary number must convert. A design using `>=` for the forward test would forward it instead.
- A bus field equal to the subordinate number must forward. An off-by-one would abort it.
- After the registers are programmed with subordinate below secondary, no cycle may be forwarded.

For device numbers 15 and 16, a design that wraps the select would raise a stray low bit in the address. For partial byte-enable writes and writes to a neighbouring dword, a design that ignores lanes would corrupt the other bus numbers, which the next read-back would expose. Back-to-back strobes check that the result pulse is not dropped or merged.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;

    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_LOCAL   = 2'd1,
        ACT_CONVERT = 2'd2,
        ACT_FORWARD = 2'd3
    } route_act_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } route_state_e;

    // dword index of the bus-number registers (byte offset 18h)
    localparam int unsigned BUSREG_DWORD = 6;

endpackage

// File: rtl/cfg_route_busregs.sv
module cfg_route_busregs #(
    parameter int unsigned BUS_W = 8,
    parameter int unsigned NREG  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [NREG-1:0]         lane_en,
    input  logic [NREG*BUS_W-1:0]   wdata,
    output logic [NREG*BUS_W-1:0]   regs_q
);

    for (genvar g = 0; g < NREG; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[g*BUS_W +: BUS_W] <= '0;
            end else if (wr_en && lane_en[g]) begin
                regs_q[g*BUS_W +: BUS_W] <= wdata[g*BUS_W +: BUS_W];
            end
        end

        AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && lane_en[g]) |=> $stable(regs_q[g*BUS_W +: BUS_W])); // R10
    end

endmodule

// File: rtl/cfg_route_decode.sv
module cfg_route_decode
    import cfg_route_pkg::*;
#(
    parameter int unsigned AW          = 32,
    parameter int unsigned BUS_W       = 8,
    parameter int unsigned BUS_LSB     = 16,
    parameter int unsigned DEV_W       = 5,
    parameter int unsigned DEV_LSB     = 11,
    parameter int unsigned IDSEL_BASE  = 16,
    parameter int unsigned IDSEL_COUNT = 16
) (
    input  logic [AW-1:0]    addr,
    input  logic             idsel_in,
    input  logic [BUS_W-1:0] sec_bus,
    input  logic [BUS_W-1:0] sub_bus,
    output route_act_e       act,
    output logic [AW-1:0]    xlat_addr
);

    logic [BUS_W-1:0]       bus_num;
    logic [DEV_W-1:0]       dev_num;
    logic [IDSEL_COUNT-1:0] idsel_vec;
    logic [AW-1:0]          conv_addr;
    logic                   is_type1;
    logic                   is_type0;
    logic                   hit_sec;
    logic                   hit_below;

    assign bus_num  = addr[BUS_LSB +: BUS_W];
    assign dev_num  = addr[DEV_LSB +: DEV_W];
    assign is_type1 = (addr[1:0] == 2'b01);
    assign is_type0 = (addr[1:0] == 2'b00);

    // one select line per low device number; higher numbers select none
    for (genvar g = 0; g < IDSEL_COUNT; g++) begin : g_idsel
        assign idsel_vec[g] = (dev_num == DEV_W'(g));
    end

    always_comb begin
        conv_addr                               = '0;
        conv_addr[DEV_LSB-1:2]                  = addr[DEV_LSB-1:2];
        conv_addr[IDSEL_BASE +: IDSEL_COUNT]    = idsel_vec;
    end

    assign hit_sec   = (bus_num == sec_bus);
    assign hit_below = (bus_num > sec_bus) && (bus_num <= sub_bus);

    always_comb begin
        act       = ACT_NONE;
        xlat_addr = '0;
        if (is_type1) begin
            if (hit_sec) begin
                act       = ACT_CONVERT;
                xlat_addr = conv_addr;
            end else if (hit_below) begin
                act       = ACT_FORWARD;
                xlat_addr = addr;
            end
        end else if (is_type0 && idsel_in) begin
            act = ACT_LOCAL;
        end
    end

endmodule

// File: rtl/cfg_route_top.sv
module cfg_route_top
    import cfg_route_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned BUS_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ap_strobe,
    input  logic [AW-1:0] ap_addr,
    input  logic          ap_is_write,
    input  logic          ap_idsel,
    input  logic [3:0]    ap_byte_en,
    input  logic [AW-1:0] ap_wdata,
    output logic          res_vld,
    output logic [1:0]    res_act,
    output logic          res_claim,
    output logic [AW-1:0] res_addr,
    output logic [AW-1:0] res_rdata
);

    localparam int unsigned NREG   = 3;
    localparam int unsigned REGS_W = NREG * BUS_W;
    localparam int unsigned REGN_W = 6;

    route_state_e       state_q, state_d;
    route_act_e         dec_act;
    route_act_e         act_q;
    logic [AW-1:0]      dec_addr;
    logic [REGS_W-1:0]  bus_regs;
    logic               reg_hit;
    logic               wr_en;
    logic [AW-1:0]      rdata_d;
    logic               claim_q;
    logic [AW-1:0]      addr_q;
    logic [AW-1:0]      rdata_q;

    cfg_route_busregs #(.BUS_W(BUS_W), .NREG(NREG)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .lane_en (ap_byte_en[NREG-1:0]),
        .wdata   (ap_wdata[REGS_W-1:0]),
        .regs_q  (bus_regs)
    );

    cfg_route_decode #(.AW(AW), .BUS_W(BUS_W)) u_dec (
        .addr      (ap_addr),
        .idsel_in  (ap_idsel),
        .sec_bus   (bus_regs[BUS_W +: BUS_W]),
        .sub_bus   (bus_regs[2*BUS_W +: BUS_W]),
        .act       (dec_act),
        .xlat_addr (dec_addr)
    );

    assign reg_hit = (ap_addr[2 +: REGN_W] == REGN_W'(BUSREG_DWORD));
    assign wr_en   = ap_strobe && (dec_act == ACT_LOCAL) && ap_is_write && reg_hit;

    always_comb begin
        rdata_d = '0;
        if ((dec_act == ACT_LOCAL) && !ap_is_write && reg_hit) begin
            rdata_d[REGS_W-1:0] = bus_regs;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = ap_strobe ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = ap_strobe ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= ACT_NONE;
            claim_q <= 1'b0;
            addr_q  <= '0;
            rdata_q <= '0;
        end else if (ap_strobe) begin
            act_q   <= dec_act;
            claim_q <= (dec_act != ACT_NONE);
            addr_q  <= dec_addr;
            rdata_q <= rdata_d;
        end
    end

    // outputs
    always_comb begin
        res_vld   = (state_q == ST_REPORT);
        res_act   = act_q;
        res_claim = claim_q;
        res_addr  = addr_q;
        res_rdata = rdata_q;
    end

    AST_VLD_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> $past(ap_strobe)); // R2
    AST_STROBE_GIVES_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        ap_strobe |=> res_vld); // R2
    AST_CONV_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && res_act == 2'd2) |-> (res_addr[15:11] == 5'd0 && res_addr[1:0] == 2'b00)); // R4
    AST_IDSEL_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && res_act == 2'd2) |-> $onehot0(res_addr[31:16])); // R5
    AST_FWD_TYPE1: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && res_act == 2'd3) |-> (res_addr[1:0] == 2'b01)); // R6
    AST_NOCLAIM_NOADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && !res_claim) |-> (res_addr == '0)); // R7

endmodule

// File: tb/cfg_route_top_tb_top.sv
`timescale 1ns/1ps
module cfg_route_top_tb_top;

    localparam real HALF = 2.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ap_strobe = 1'b0;
    logic [31:0] ap_addr = '0;
    logic        ap_is_write = 1'b0;
    logic        ap_idsel = 1'b0;
    logic [3:0]  ap_byte_en = '0;
    logic [31:0] ap_wdata = '0;
    logic        res_vld;
    logic [1:0]  res_act;
    logic        res_claim;
    logic [31:0] res_addr;
    logic [31:0] res_rdata;

    int tests = 0;
    int fails = 0;
    int m_pri = 0, m_sec = 0, m_sub = 0;

    always #(HALF) clk = ~clk;

    cfg_route_top dut_i (
        .clk(clk), .rst_n(rst_n), .ap_strobe(ap_strobe), .ap_addr(ap_addr),
        .ap_is_write(ap_is_write), .ap_idsel(ap_idsel), .ap_byte_en(ap_byte_en),
        .ap_wdata(ap_wdata), .res_vld(res_vld), .res_act(res_act),
        .res_claim(res_claim), .res_addr(res_addr), .res_rdata(res_rdata)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] t1(int bus, int dev, int fn, int rg);
        return {8'h00, 8'(bus), 5'(dev), 3'(fn), 6'(rg), 2'b01};
    endfunction

    function automatic logic [31:0] t0(int fn, int rg);
        return {21'h0, 3'(fn), 6'(rg), 2'b00};
    endfunction

    // one clock: drive at negedge, predict, compare at next negedge
    task automatic cyc(string req, bit s, logic [31:0] a, bit w, bit id,
                       logic [3:0] be, logic [31:0] d);
        int e_act = 0;
        logic [31:0] e_addr = '0;
        logic [31:0] e_rd = '0;
        int bus, dev, rg;
        ap_strobe = s; ap_addr = a; ap_is_write = w; ap_idsel = id;
        ap_byte_en = be; ap_wdata = d;
        bus = int'(a[23:16]); dev = int'(a[15:11]); rg = int'(a[7:2]);
        if (s) begin
            if (a[1:0] == 2'b01) begin
                if (bus == m_sec) begin
                    e_act = 2;
                    e_addr = (a & 32'h0000_07FC);
                    if (dev < 16) e_addr = e_addr | (32'h1 << (16 + dev));
                end else if (bus > m_sec && bus <= m_sub) begin
                    e_act = 3;
                    e_addr = a;
                end
            end else if (a[1:0] == 2'b00 && id) begin
                e_act = 1;
                if (rg == 6) begin
                    if (!w) e_rd = {8'h00, 8'(m_sub), 8'(m_sec), 8'(m_pri)};
                    else begin
                        if (be[0]) m_pri = int'(d[7:0]);
                        if (be[1]) m_sec = int'(d[15:8]);
                        if (be[2]) m_sub = int'(d[23:16]);
                    end
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk(req, "res_vld", 32'(res_vld), 32'(s));
        if (s) begin
            chk(req, "res_act", 32'(res_act), 32'(e_act));
            chk(req, "res_claim", 32'(res_claim), 32'(e_act != 0));
            chk(req, "res_addr", res_addr, e_addr);
            chk(req, "res_rdata", res_rdata, e_rd);
        end
    endtask

    task automatic idle(string req);
        cyc(req, 1'b0, 32'h0, 1'b0, 1'b0, 4'h0, 32'h0);
    endtask

    task automatic wr_regs(string req, int rg, logic [3:0] be, logic [31:0] d);
        cyc(req, 1'b1, t0(0, rg), 1'b1, 1'b1, be, d);
    endtask

    task automatic rd_regs(string req, int rg);
        cyc(req, 1'b1, t0(0, rg), 1'b0, 1'b1, 4'hF, 32'h0);
    endtask

    initial begin
        #(HALF * 2.0 * 200000.0);
        fails++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "res_vld", 32'(res_vld), 32'h0);
        chk("R1", "res_addr", res_addr, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "res_claim", 32'(res_claim), 32'h0);
        rd_regs("R1_R11", 6);                       // all zero after reset
        cyc("R3_R4", 1'b1, t1(0, 3, 2, 5), 1'b0, 1'b0, 4'h0, 32'h0);

        wr_regs("R10", 6, 4'b0111, 32'hAA05_0201);  // pri 1 sec 2 sub 5
        rd_regs("R11", 6);
        cyc("R4", 1'b1, t1(2, 0, 7, 63), 1'b0, 1'b0, 4'h0, 32'h0);
        cyc("R4", 1'b1, t1(2, 15, 1, 9), 1'b0, 1'b0, 4'h0, 32'h0);
        cyc("R5", 1'b1, t1(2, 16, 0, 1), 1'b0, 1'b0, 4'h0, 32'h0);
        cyc("R5", 1'b1, t1(2, 31, 7, 2), 1'b0, 1'b0, 4'h0, 32'h0);
        idle("R2");
        cyc("R6", 1'b1, t1(3, 4, 0, 0), 1'b0, 1'b0, 4'h0, 32'h0);
        cyc("R6", 1'b1, t1(5, 9, 3, 3), 1'b0, 1'b0, 4'h0, 32'h0);
        cyc("R7", 1'b1, t1(6, 1, 0, 0), 1'b0, 1'b0, 4'h0, 32'h0);
        cyc("R7", 1'b1, t1(1, 1, 0, 0), 1'b0, 1'b0, 4'h0, 32'h0);
        cyc("R7", 1'b1, t1(0, 1, 0, 0), 1'b0, 1'b0, 4'h0, 32'h0);
        cyc("R7", 1'b1, t1(255, 1, 0, 0), 1'b0, 1'b0, 4'h0, 32'h0);
        cyc("R8", 1'b1, t0(0, 6), 1'b0, 1'b0, 4'hF, 32'h0);
        cyc("R8", 1'b1, t0(0, 5), 1'b0, 1'b1, 4'hF, 32'h0);
        cyc("R9", 1'b1, t0(0, 6) | 32'h2, 1'b1, 1'b1, 4'hF, 32'h00FF_FFFF);
        cyc("R9", 1'b1, t0(0, 6) | 32'h3, 1'b0, 1'b1, 4'hF, 32'h0);
        rd_regs("R9_R11", 6);
        wr_regs("R10", 6, 4'b0010, 32'h0009_070A);  // only secondary -> 7
        rd_regs("R10_R11", 6);
        wr_regs("R10", 6, 4'b1000, 32'hFFFF_FFFF);  // lane 3 ignored
        wr_regs("R10", 7, 4'b0111, 32'h0033_2211);  // other dword ignored
        cyc("R10", 1'b1, t0(0, 6), 1'b1, 1'b0, 4'hF, 32'h0011_2233); // not local
        rd_regs("R10_R11", 6);
        cyc("R7", 1'b1, t1(6, 2, 0, 0), 1'b0, 1'b0, 4'h0, 32'h0); // sub<sec
        cyc("R3", 1'b1, t1(7, 2, 0, 0), 1'b0, 1'b0, 4'h0, 32'h0);
        wr_regs("R10", 6, 4'b0111, 32'h0008_0300);  // pri 0 sec 3 sub 8
        cyc("R2", 1'b1, t1(3, 5, 0, 0), 1'b0, 1'b0, 4'h0, 32'h0);
        cyc("R2", 1'b1, t1(8, 5, 0, 0), 1'b0, 1'b0, 4'h0, 32'h0);
        idle("R2");
        idle("R2");
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            a = $urandom;
            a[23:16] = 8'($urandom_range(0, 10));
            if ($urandom_range(0, 3) == 0) a[7:2] = 6'd6;
            if ($urandom_range(0, 7) == 0) begin
                cyc("R2_R3_R6_R7_R8", 1'b1, a, $urandom_range(0, 1) == 1,
                    1'b1, 4'($urandom), 32'($urandom_range(0, 12)) * 32'h0001_0101);
            end else begin
                cyc("R2_R3_R6_R7_R8", $urandom_range(0, 4) != 0, a, 1'b0,
                    $urandom_range(0, 1) == 1, 4'h0, 32'h0);
            end
        end
        rd_regs("R11", 6);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule